// File: doc/BRIEF.md
# Sixteen-Bit Capture/Reload Timer

This block is a counter core with a companion register that serves two purposes. In capture mode the companion register stores a snapshot of the counter whenever the external strobe pin falls. In reload mode it holds the start value that the counter takes on after each overflow. A third mode, clock output, runs the counter in reload mode and toggles an output pin on every overflow. This gives a square wave whose period is set by the reload value. Rollovers in that mode do not interrupt the processor.

The counter advances once per clock cycle in which both `run` and `tick` are high. Any prescaling of `tick` happens outside the block. In reload mode, a direction-enable input lets the external strobe pin also select the count direction. Software accesses the counter, the companion register and the two event flags through a byte-wide write port and a combinational read port. The interrupt request is the OR of the two flags, except in clock-output mode, where it is masked.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the counter, the companion register, both flags, `irq` and `t2_out` are all zero.
- R2: The byte map is: address 0 is counter bits 7:0, 1 is counter bits 15:8, 2 is companion bits 7:0, 3 is companion bits 15:8, and 4 is flags (bit 0 overflow, bit 1 external). Addresses 5 to 7 read as zero and ignore writes. A write takes effect at the next clock edge. A counter write in a cycle with a tick replaces the tick, and the unwritten counter byte holds.
- R3: In reload mode counting up, a tick at FFFFh loads the companion value and sets the overflow flag; any other tick adds one.
- R4: In reload mode with `down_en` = 1, the counter counts up while `ext_pin` = 1 and down while `ext_pin` = 0. When counting down, a tick while the counter equals the companion value loads FFFFh and sets the overflow flag. With `down_en` = 0 it always counts up.
- R5: In capture mode (`cap_mode` = 1), a falling edge of `ext_pin` with `ext_en` = 1 copies the counter into the companion register and sets the external flag. Here a fall means high in the previous cycle and low now. In this mode an up-count past FFFFh wraps to 0000h and sets the overflow flag.
- R6: In reload mode with `down_en` = 0, a qualified falling edge loads the counter from the companion register and sets the external flag; this replaces any tick in that cycle. With `down_en` = 1, edges do nothing.
- R7: With `ext_en` = 0, falling edges of `ext_pin` change neither the companion register nor the external flag.
- R8: Clock-output mode is active when `clk_out_en` = 1 and `ct_sel` = 0. In this mode the counter counts up, and each overflow reloads it and toggles `t2_out` without setting the overflow flag. A companion value C gives a period of 2 × (65536 − C) ticks.
- R9: `irq` equals overflow OR external flag, and is forced low in clock-output mode. Flags clear only through a write to address 4. If a hardware set and a clearing write coincide, the set wins.
- R10: When `run` or `tick` is low, the counter holds unless it is written or reloaded by an edge.
- R11: `t2_oe` is high only in clock-output mode. Outside that mode `t2_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse |
| run | input | 1 | Timer run control |
| ext_pin | input | 1 | External strobe / direction pin |
| ext_en | input | 1 | Enables falling-edge events on `ext_pin` |
| cap_mode | input | 1 | 1 selects capture mode, 0 selects reload mode |
| down_en | input | 1 | Lets `ext_pin` select direction in reload mode |
| clk_out_en | input | 1 | Requests clock-output mode |
| ct_sel | input | 1 | Counter/timer select; must be 0 for clock output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Read byte (combinational) |
| count_val | output | 16 | Counter value |
| cap_val | output | 16 | Companion capture/reload register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External event flag |
| irq | output | 1 | Interrupt request |
| t2_out | output | 1 | Clock output level |
| t2_oe | output | 1 | Clock output enable |

## Verification
Directed sequences run the counter up across FFFFh and down onto the companion value. These separate the up and down overflow rules, and whether the reload value or wrap-to-zero applies in each mode. Edge sequences toggle `ext_pin` with `ext_en`, `cap_mode` and `down_en` in different combinations, which distinguishes capture, edge reload and ignored edges. Coincident-event cycles exercise the stated priorities: a write with a tick, and a clearing flag write with an overflow. A long random phase with biased tick, pin and write traffic is then compared every cycle against a behavioural model, including reads of unused addresses.

// File: rtl/cr_tmr_pkg.sv
package cr_tmr_pkg;

   localparam int TM_BYTE_W = 8;

   typedef enum logic [1:0] {
      TM_RELOAD  = 2'd0,
      TM_CAPTURE = 2'd1,
      TM_CLKOUT  = 2'd2
   } tm_mode_e;

   // Clock output overrides the capture/reload choice.
   function automatic tm_mode_e tm_decode(input logic cap_mode,
                                          input logic clk_out_en,
                                          input logic ct_sel);
      if (clk_out_en && !ct_sel)
         return TM_CLKOUT;
      else if (cap_mode)
         return TM_CAPTURE;
      return TM_RELOAD;
   endfunction

endpackage

// File: rtl/cr_tmr_edge.sv
module cr_tmr_edge #(
   parameter int SYNC_STAGES = 0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic fall
);
   logic prev_q;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("cr_tmr_edge: SYNC_STAGES must be 0..3");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign level = pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= pin;
               for (int i = 1; i < SYNC_STAGES; i++)
                  sh_q[i] <= sh_q[i-1];
            end
         end
         assign level = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign fall = prev_q & ~level;

endmodule

// File: rtl/cr_tmr_counter.sv
module cr_tmr_counter
   import cr_tmr_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int NB = CNT_W / TM_BYTE_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic                 down,
   input  tm_mode_e             mode,
   input  logic                 reload_now,
   input  logic [CNT_W-1:0]     reload_val,
   input  logic [NB-1:0]        lane_wr,
   input  logic [TM_BYTE_W-1:0] wr_byte,
   output logic [CNT_W-1:0]     cnt,
   output logic                 wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d, stepped, written;
   logic             wrap_raw, any_wr;

   assign any_wr = |lane_wr;

   generate
      for (genvar i = 0; i < NB; i++) begin : g_lane
         assign written[i*TM_BYTE_W +: TM_BYTE_W] =
            lane_wr[i] ? wr_byte : cnt_q[i*TM_BYTE_W +: TM_BYTE_W];
      end
   endgenerate

   // Value after one tick, and whether that tick is an overflow.
   always_comb begin
      wrap_raw = 1'b0;
      if (down) begin
         if (cnt_q == reload_val) begin
            stepped  = '1;
            wrap_raw = 1'b1;
         end else begin
            stepped = cnt_q - ONE;
         end
      end else if (&cnt_q) begin
         stepped  = (mode == TM_CAPTURE) ? '0 : reload_val;
         wrap_raw = 1'b1;
      end else begin
         stepped = cnt_q + ONE;
      end
   end

   // Priority: software write, then edge reload, then tick.
   always_comb begin
      if (any_wr)
         cnt_d = written;
      else if (reload_now)
         cnt_d = reload_val;
      else if (step)
         cnt_d = stepped;
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign wrap = step & ~any_wr & ~reload_now & wrap_raw;
   assign cnt  = cnt_q;

endmodule

// File: rtl/cr_tmr_capreg.sv
module cr_tmr_capreg
   import cr_tmr_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int NB = CNT_W / TM_BYTE_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture_now,
   input  logic [CNT_W-1:0]     snap,
   input  logic [NB-1:0]        lane_wr,
   input  logic [TM_BYTE_W-1:0] wr_byte,
   output logic [CNT_W-1:0]     value
);
   generate
      for (genvar i = 0; i < NB; i++) begin : g_lane
         logic [TM_BYTE_W-1:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q <= '0;
            else if (lane_wr[i])
               byte_q <= wr_byte;
            else if (capture_now)
               byte_q <= snap[i*TM_BYTE_W +: TM_BYTE_W];
         end
         assign value[i*TM_BYTE_W +: TM_BYTE_W] = byte_q;
      end
   endgenerate

endmodule

// File: rtl/cr_tmr_flags.sv
module cr_tmr_flags
   import cr_tmr_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_ovf,
   input  logic                 set_ext,
   input  logic                 toggle,
   input  logic                 mask,
   input  logic                 flag_wr,
   input  logic [TM_BYTE_W-1:0] wr_byte,
   output logic                 ovf,
   output logic                 ext,
   output logic                 t2_out,
   output logic                 irq
);
   logic ovf_q, ext_q, t2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         ext_q <= 1'b0;
         t2_q  <= 1'b0;
      end else begin
         ovf_q <= set_ovf | (flag_wr ? wr_byte[0] : ovf_q);
         ext_q <= set_ext | (flag_wr ? wr_byte[1] : ext_q);
         t2_q  <= t2_q ^ toggle;
      end
   end

   assign ovf    = ovf_q;
   assign ext    = ext_q;
   assign t2_out = t2_q;
   assign irq    = (ovf_q | ext_q) & ~mask;

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
   import cr_tmr_pkg::*;
#(
   parameter int CNT_W           = 16,
   parameter int ADDR_W          = 3,
   parameter int EXT_SYNC_STAGES = 0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 run,
   input  logic                 ext_pin,
   input  logic                 ext_en,
   input  logic                 cap_mode,
   input  logic                 down_en,
   input  logic                 clk_out_en,
   input  logic                 ct_sel,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [7:0]           wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [7:0]           rd_data,
   output logic [CNT_W-1:0]     count_val,
   output logic [CNT_W-1:0]     cap_val,
   output logic                 ovf_flag,
   output logic                 ext_flag,
   output logic                 irq,
   output logic                 t2_out,
   output logic                 t2_oe
);
   localparam int NB        = CNT_W / TM_BYTE_W;
   localparam int FLAG_ADDR = 2 * NB;

   generate
      if (CNT_W % TM_BYTE_W != 0 || CNT_W < 8 || CNT_W > 64) begin : g_bad_width
         $error("cap_reload_timer: CNT_W must be a multiple of 8 in 8..64");
      end
      if (ADDR_W < 1 || ADDR_W > 8 || (1 << ADDR_W) <= FLAG_ADDR) begin : g_bad_addr
         $error("cap_reload_timer: ADDR_W too small for the byte map");
      end
   endgenerate

   tm_mode_e        mode;
   logic            ext_level, ext_fall, ext_event;
   logic            reload_now, capture_now, step, count_down, wrap, flag_wr;
   logic [NB-1:0]   cnt_lane, cap_lane;

   assign mode        = tm_decode(cap_mode, clk_out_en, ct_sel);
   assign step        = run & tick;
   // With direction control enabled the pin steers, so its edges are inert.
   assign ext_event   = ext_en & ext_fall & ~((mode == TM_RELOAD) & down_en);
   assign reload_now  = ext_event & (mode == TM_RELOAD);
   assign capture_now = ext_event & (mode == TM_CAPTURE);
   assign count_down  = (mode == TM_RELOAD) & down_en & ~ext_level;
   assign flag_wr     = wr_en && (wr_addr == ADDR_W'(FLAG_ADDR));

   generate
      for (genvar i = 0; i < NB; i++) begin : g_dec
         assign cnt_lane[i] = wr_en && (wr_addr == ADDR_W'(i));
         assign cap_lane[i] = wr_en && (wr_addr == ADDR_W'(NB + i));
      end
   endgenerate

   cr_tmr_edge #(.SYNC_STAGES(EXT_SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin),
      .level (ext_level),
      .fall  (ext_fall)
   );

   cr_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .down       (count_down),
      .mode       (mode),
      .reload_now (reload_now),
      .reload_val (cap_val),
      .lane_wr    (cnt_lane),
      .wr_byte    (wr_data),
      .cnt        (count_val),
      .wrap       (wrap)
   );

   cr_tmr_capreg #(.CNT_W(CNT_W)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_now (capture_now),
      .snap        (count_val),
      .lane_wr     (cap_lane),
      .wr_byte     (wr_data),
      .value       (cap_val)
   );

   cr_tmr_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ovf (wrap & (mode != TM_CLKOUT)),
      .set_ext (ext_event),
      .toggle  (wrap & (mode == TM_CLKOUT)),
      .mask    (mode == TM_CLKOUT),
      .flag_wr (flag_wr),
      .wr_byte (wr_data),
      .ovf     (ovf_flag),
      .ext     (ext_flag),
      .t2_out  (t2_out),
      .irq     (irq)
   );

   assign t2_oe = (mode == TM_CLKOUT);

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NB; i++) begin
         if (rd_addr == ADDR_W'(i))
            rd_data = count_val[i*TM_BYTE_W +: TM_BYTE_W];
         if (rd_addr == ADDR_W'(NB + i))
            rd_data = cap_val[i*TM_BYTE_W +: TM_BYTE_W];
      end
      if (rd_addr == ADDR_W'(FLAG_ADDR))
         rd_data = {6'b0, ext_flag, ovf_flag};
   end

endmodule

// File: rtl/cr_tmr_chk.sv
module cr_tmr_chk #(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             run,
   input logic             ext_en,
   input logic             cap_mode,
   input logic             down_en,
   input logic             clk_out_en,
   input logic             ct_sel,
   input logic             wr_en,
   input logic             ext_level,
   input logic             ext_fall,
   input logic [CNT_W-1:0] count_val,
   input logic [CNT_W-1:0] cap_val,
   input logic             ovf_flag,
   input logic             ext_flag,
   input logic             irq,
   input logic             t2_out,
   input logic             t2_oe
);
   logic clkout_m;
   assign clkout_m = clk_out_en && !ct_sel;

   // R3: up-count overflow in reload mode
   p_ovf_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !wr_en && !clkout_m && !cap_mode && (!down_en || ext_level)
       && (&count_val) && !ext_fall)
      |=> (count_val == $past(cap_val)) && ovf_flag);

   // R4: down-count reaching the companion value
   p_down_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !wr_en && !clkout_m && !cap_mode && down_en && !ext_level
       && (count_val == cap_val))
      |=> (&count_val) && ovf_flag);

   // R5: capture on qualified falling edge
   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_en && ext_fall && cap_mode && !clkout_m && !wr_en)
      |=> (cap_val == $past(count_val)) && ext_flag);

   // R7: disabled edges leave the companion register alone
   p_ext_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_en && !wr_en && cap_mode && !clkout_m) |=> $stable(cap_val));

   // R8: clock-output overflow does not set the overflow flag
   p_clkout_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clkout_m && !ovf_flag && !wr_en) |=> !ovf_flag);

   // R9: interrupt masked in clock-output mode
   p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clkout_m |-> !irq);

   // R9: flags stay set without a write
   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !wr_en) |=> ovf_flag);

   // R10: idle counter holds
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && tick) && !wr_en && !ext_en) |=> $stable(count_val));

   // R11: output level frozen while not driven
   p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !t2_oe |=> $stable(t2_out));

endmodule

bind cap_reload_timer cr_tmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .run        (run),
   .ext_en     (ext_en),
   .cap_mode   (cap_mode),
   .down_en    (down_en),
   .clk_out_en (clk_out_en),
   .ct_sel     (ct_sel),
   .wr_en      (wr_en),
   .ext_level  (ext_level),
   .ext_fall   (ext_fall),
   .count_val  (count_val),
   .cap_val    (cap_val),
   .ovf_flag   (ovf_flag),
   .ext_flag   (ext_flag),
   .irq        (irq),
   .t2_out     (t2_out),
   .t2_oe      (t2_oe)
);

// File: tb/cap_reload_timer_tb.sv
module cap_reload_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick = 0, run = 0, ext_pin = 0, ext_en = 0, cap_mode = 0, down_en = 0;
   logic clk_out_en = 0, ct_sel = 0, wr_en = 0;
   logic [2:0] wr_addr = 0, rd_addr = 0;
   logic [7:0] wr_data = 0, rd_data;
   logic [15:0] count_val, cap_val;
   logic ovf_flag, ext_flag, irq, t2_out, t2_oe;

   int n_vec = 0, n_fail = 0, cycles = 0;
   bit done = 0;

   cap_reload_timer u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   // Behavioural reference state
   logic [15:0] m_cnt, m_cap;
   bit m_ovf, m_ext, m_t2, m_prev;
   bit co, fall, ev, dn, stp, wrp;
   logic [15:0] nc, ncap;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_cap = 0; m_ovf = 0; m_ext = 0; m_t2 = 0; m_prev = 0;
      end else begin
         co   = clk_out_en && !ct_sel;
         fall = m_prev && !ext_pin;
         m_prev = ext_pin;
         ev   = ext_en && fall && !(!co && !cap_mode && down_en);
         dn   = !co && !cap_mode && down_en && !ext_pin;
         stp  = run && tick;
         wrp  = 0;
         nc   = m_cnt;
         ncap = m_cap;
         if (wr_en && wr_addr == 0)      nc[7:0] = wr_data;
         else if (wr_en && wr_addr == 1) nc[15:8] = wr_data;
         else if (ev && !co && !cap_mode) nc = m_cap;
         else if (stp) begin
            if (dn) begin
               if (m_cnt == m_cap) begin nc = 16'hFFFF; wrp = 1; end
               else nc = m_cnt - 1;
            end else if (m_cnt == 16'hFFFF) begin
               wrp = 1;
               nc = (cap_mode && !co) ? 16'h0000 : m_cap;
            end else nc = m_cnt + 1;
         end
         if (ev && cap_mode && !co) ncap = m_cnt;
         if (wr_en && wr_addr == 2) ncap[7:0]  = wr_data;
         if (wr_en && wr_addr == 3) ncap[15:8] = wr_data;
         if (wr_en && wr_addr == 4) begin m_ovf = wr_data[0]; m_ext = wr_data[1]; end
         if (wrp && !co) m_ovf = 1;
         if (ev) m_ext = 1;
         if (wrp && co) m_t2 = !m_t2;
         m_cnt = nc;
         m_cap = ncap;
      end
   end

   function automatic logic [7:0] model_read(input logic [2:0] a);
      case (a)
         3'd0: return m_cnt[7:0];
         3'd1: return m_cnt[15:8];
         3'd2: return m_cap[7:0];
         3'd3: return m_cap[15:8];
         3'd4: return {6'b0, m_ext, m_ovf};
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(count_val, m_cnt, "R3 count");
         chk(cap_val, m_cap, "R5 companion");
         chk(ovf_flag, m_ovf, "R4 ovf flag");
         chk(ext_flag, m_ext, "R6 ext flag");
         chk(irq, (m_ovf | m_ext) & !(clk_out_en && !ct_sel), "R9 irq");
         chk(t2_out, m_t2, "R8 t2_out");
         chk(t2_oe, clk_out_en && !ct_sel, "R11 t2_oe");
         chk(rd_data, model_read(rd_addr), "R2 rd_data");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   task automatic cyc();
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 0;
   endtask

   initial begin
      cyc(); cyc();
      // R1 reset state
      chk(count_val, 0, "R1 count"); chk(cap_val, 0, "R1 companion");
      chk({ovf_flag, ext_flag, irq, t2_out}, 0, "R1 flags");
      rst_n = 1;
      cyc();

      // R2 byte map
      wr(0, 8'hF0); wr(1, 8'hFF); wr(2, 8'h34); wr(3, 8'h12);
      chk(count_val, 16'hFFF0, "R2 counter write");
      chk(cap_val, 16'h1234, "R2 companion write");
      rd_addr = 3; #1; chk(rd_data, 8'h12, "R2 read addr3");
      wr(7, 8'hAA);
      rd_addr = 6; #1; chk(rd_data, 8'h00, "R2 unused addr");
      chk(count_val, 16'hFFF0, "R2 unused write ignored");

      // R3 up count through FFFFh
      ext_pin = 1; run = 1; tick = 1;
      repeat (15) cyc();
      chk(count_val, 16'hFFFF, "R3 reach top");
      cyc(); run = 0;
      chk(count_val, 16'h1234, "R3 reload");
      chk(ovf_flag, 1, "R3 overflow flag");
      chk(irq, 1, "R9 irq on flag");
      wr(4, 8'h00);
      chk({ovf_flag, irq}, 0, "R9 clear by write");

      // R4 direction control
      wr(0, 8'h36);
      down_en = 1; ext_pin = 0; run = 1;
      cyc(); cyc();
      chk(count_val, 16'h1234, "R4 count down");
      chk(ovf_flag, 0, "R4 no flag yet");
      cyc(); run = 0;
      chk(count_val, 16'hFFFF, "R4 down floor load");
      chk(ovf_flag, 1, "R4 down overflow");
      wr(0, 8'h00); wr(1, 8'h10);
      ext_pin = 1; run = 1;
      repeat (3) cyc();
      chk(count_val, 16'h1003, "R4 up with pin high");
      down_en = 0; ext_pin = 0;
      repeat (3) cyc();
      run = 0;
      chk(count_val, 16'h1006, "R4 down_en low counts up");

      // R5 capture, R7 ignored edges
      wr(4, 8'h00);
      cap_mode = 1; ext_en = 1; ext_pin = 1; cyc();
      ext_pin = 0; cyc();
      chk(cap_val, 16'h1006, "R5 capture");
      chk(ext_flag, 1, "R5 ext flag");
      ext_pin = 1; ext_en = 0; cyc();
      wr(4, 8'h00);
      ext_pin = 0; cyc();
      chk(cap_val, 16'h1006, "R7 companion unchanged");
      chk(ext_flag, 0, "R7 flag unchanged");
      wr(0, 8'hFF); wr(1, 8'hFF);
      run = 1; cyc(); run = 0;
      chk(count_val, 16'h0000, "R5 wrap to zero");
      chk(ovf_flag, 1, "R5 wrap flag");

      // R6 edge reload
      cap_mode = 0; ext_en = 1; ext_pin = 1; cyc();
      wr(2, 8'h22); wr(3, 8'h22); wr(4, 8'h00);
      ext_pin = 0; cyc();
      chk(count_val, 16'h2222, "R6 edge reload");
      chk(ext_flag, 1, "R6 edge flag");
      ext_pin = 1; down_en = 1; cyc();
      wr(4, 8'h00); wr(0, 8'h05); wr(1, 8'h00);
      ext_pin = 0; cyc();
      chk(count_val, 16'h0005, "R6 edge ignored with down_en");
      chk(ext_flag, 0, "R6 no flag with down_en");
      down_en = 0; ext_en = 0;

      // R8 clock output
      clk_out_en = 1; ct_sel = 0;
      wr(4, 8'h00); wr(2, 8'hFC); wr(3, 8'hFF); wr(0, 8'hFC); wr(1, 8'hFF);
      chk(t2_oe, 1, "R11 oe in clock mode");
      run = 1; tick = 1;
      repeat (4) cyc();
      chk(t2_out, 1, "R8 first toggle");
      chk(ovf_flag, 0, "R8 no overflow flag");
      repeat (4) cyc();
      run = 0;
      chk(t2_out, 0, "R8 period 8 ticks");
      wr(4, 8'h03);
      chk(irq, 0, "R9 masked in clock mode");
      ct_sel = 1; cyc();
      chk(irq, 1, "R9 unmasked");
      chk(t2_oe, 0, "R11 oe low with ct_sel");
      run = 1; cyc(); run = 0;
      chk(t2_out, 0, "R11 output holds");

      // R9 set beats clear
      ct_sel = 0; clk_out_en = 0;
      wr(0, 8'hFF);
      wr_en = 1; wr_addr = 4; wr_data = 0; run = 1; tick = 1;
      cyc();
      wr_en = 0; run = 0;
      chk(count_val, 16'hFFFC, "R9 overflow same cycle");
      chk(ovf_flag, 1, "R9 set wins over clear");
      chk(ext_flag, 0, "R9 ext cleared");

      // R2 write beats tick, R10 hold
      run = 1; tick = 1;
      wr(0, 8'h10);
      tick = 0;
      chk(count_val, 16'hFF10, "R2 write replaces tick");
      repeat (3) cyc();
      run = 0;
      chk(count_val, 16'hFF10, "R10 hold without tick");

      // Random traffic against the reference
      for (int k = 0; k < 4000; k++) begin
         tick       = ($urandom % 4) != 0;
         run        = ($urandom % 8) != 0;
         if ($urandom % 4 == 0) ext_pin = ~ext_pin;
         if ($urandom % 64 == 0) ext_en = ~ext_en;
         if ($urandom % 64 == 0) cap_mode = ~cap_mode;
         if ($urandom % 64 == 0) down_en = ~down_en;
         if ($urandom % 96 == 0) clk_out_en = ~clk_out_en;
         if ($urandom % 96 == 0) ct_sel = ~ct_sel;
         wr_en   = ($urandom % 8) == 0;
         wr_addr = 3'($urandom);
         wr_data = ($urandom % 2) ? 8'hFF : 8'($urandom);
         rd_addr = 3'($urandom);
         cyc();
      end
      wr_en = 0;
      cyc();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule